// File: doc/BRIEF.md
# Programmable Periodic Event Divider

This block turns a 32.768 kHz time-base enable into three timing outputs for a real-time clock. It has one shared 15-bit divider chain. A logarithmic 4-bit rate code selects a power-of-two tap of that chain, and the selected tap produces a one-cycle periodic strobe for the interrupt logic. The same chain wraps once every 32768 time-base ticks, and that wrap gives the one-second tick for the calendar counter. A square-wave pin toggles on each periodic strobe while its enable bit is set.

A small host register interface holds the configuration. The rate register carries a 3-bit divider-select field and the 4-bit rate code. The control register carries the square-wave enable. The chain runs only while the divider-select field holds the standard time-base code. Any other value holds the chain at zero, so restoring the code restarts every period from a clean origin.

Top module: `periodic_divider`

## Requirements
- R1: After reset, the rate register reads 0x26 (divider select 010, rate code 6), the control register reads 0x00, and periodic_stb, sec_tick and sqw_out are low.
- R2: While the divider-select field (rate register bits 6:4) differs from 010, the chain is held at zero and neither periodic_stb nor sec_tick pulses. After the field returns to 010, the first strobe comes a full period later.
- R3: With rate code 0, periodic_stb never pulses.
- R4: For rate codes 3 to 15 (rate register bits 3:0), periodic_stb pulses after every 2^(code-1) time-base enables, counted from the chain start. It rises in the clock cycle after the tb_en that completes the count.
- R5: Rate codes 1 and 2 give the same periods as codes 8 and 9 (128 and 256 enables).
- R6: sec_tick pulses for one cycle after every 32768 time-base enables.
- R7: When control bit 3 is set, sqw_out toggles in the same cycle as each periodic_stb. When the bit is clear, sqw_out is low from the next cycle on.
- R8: Address 0 reads as {0, select[2:0], rate[3:0]}, so bit 7 always reads 0. Address 1 reads bit 3 only and all other bits read 0.
- R9: periodic_stb is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | One-cycle enable at the 32.768 kHz time-base rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 rate register, 1 control register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address, same map as wr_addr |
| rd_data | output | 8 | Combinational read data |
| periodic_stb | output | 1 | One-cycle periodic event strobe |
| sec_tick | output | 1 | One-cycle one-second tick |
| sqw_out | output | 1 | Square-wave output |

## Verification
The strobe spacing is tried with the default rate on a continuous enable, with the shortest rate on an enable that has gaps, with the two aliased low codes, and with the slowest rate. This shows whether the period is counted in enables or in clock cycles, and whether the aliases land on the right taps. The slowest run also covers the one-second wrap, so a wrong wrap point stands apart from a wrong tap. A disabled rate code and a non-standard divider select are each run for many enables, with any strobe flagged as unexpected. The square wave is followed through an enabled run and a disabled run.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int CHAIN_W  = 15;
  localparam int RATE_W   = 4;
  localparam int SEL_W    = 3;
  localparam logic [SEL_W-1:0]  SEL_RUN  = 3'b010;
  localparam logic [RATE_W-1:0] RATE_DEF = 4'd6;
  localparam int SQW_BIT  = 3;

  // Codes 1 and 2 alias onto the taps of codes 8 and 9.
  function automatic logic [RATE_W-1:0] eff_rate(input logic [RATE_W-1:0] code);
    if (code == 4'd1 || code == 4'd2) eff_rate = code + 4'd7;
    else eff_rate = code;
  endfunction

  // Low-bit mask whose all-ones state precedes a period boundary.
  function automatic logic [CHAIN_W-1:0] tap_mask(input logic [RATE_W-1:0] code);
    logic [RATE_W-1:0] r;
    r = eff_rate(code);
    if (r == '0) tap_mask = '0;
    else tap_mask = (CHAIN_W'(1) << (r - 4'd1)) - CHAIN_W'(1);
  endfunction
endpackage

// File: rtl/pdiv_regs.sv
module pdiv_regs #(
  parameter int SEL_W  = pdiv_pkg::SEL_W,
  parameter int RATE_W = pdiv_pkg::RATE_W,
  parameter int SQW_BIT = pdiv_pkg::SQW_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_addr,
  output logic [7:0]        rd_data,
  output logic [SEL_W-1:0]  div_sel,
  output logic [RATE_W-1:0] rate_code,
  output logic              sqw_en
);
  localparam int USED_W = SEL_W + RATE_W;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[7:USED_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel   <= pdiv_pkg::SEL_RUN;
      rate_code <= pdiv_pkg::RATE_DEF;
      sqw_en    <= 1'b0;
    end else if (wr_en) begin
      if (!wr_addr) begin
        div_sel   <= wr_data[USED_W-1:RATE_W];
        rate_code <= wr_data[RATE_W-1:0];
      end else begin
        sqw_en    <= wr_data[SQW_BIT];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (!rd_addr) rd_data[USED_W-1:0] = {div_sel, rate_code};
    else          rd_data[SQW_BIT]    = sqw_en;
  end
endmodule

// File: rtl/pdiv_chain.sv
module pdiv_chain #(
  parameter int CHAIN_W = pdiv_pkg::CHAIN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tb_en,
  output logic [CHAIN_W-1:0] cnt,
  output logic               sec_tick
);
  logic wrap_evt;
  assign wrap_evt = run && tb_en && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= wrap_evt;
      if (!run)       cnt <= '0;
      else if (tb_en) cnt <= cnt + CHAIN_W'(1);
    end
  end
endmodule

// File: rtl/pdiv_tap.sv
module pdiv_tap #(
  parameter int CHAIN_W = pdiv_pkg::CHAIN_W,
  parameter int RATE_W  = pdiv_pkg::RATE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tb_en,
  input  logic [RATE_W-1:0]  rate_code,
  input  logic [CHAIN_W-1:0] cnt,
  output logic [CHAIN_W-1:0] mask,
  output logic               evt,
  output logic               periodic_stb
);
  assign mask = pdiv_pkg::tap_mask(rate_code);
  assign evt  = run && tb_en && (rate_code != '0) && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) periodic_stb <= 1'b0;
    else        periodic_stb <= evt;
  end
endmodule

// File: rtl/pdiv_sqw.sv
module pdiv_sqw (
  input  logic clk,
  input  logic rst_n,
  input  logic sqw_en,
  input  logic evt,
  output logic sqw_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sqw_out <= 1'b0;
    else if (!sqw_en) sqw_out <= 1'b0;
    else if (evt)    sqw_out <= ~sqw_out;
  end
endmodule

// File: rtl/periodic_divider.sv
module periodic_divider #(
  parameter int CHAIN_W = pdiv_pkg::CHAIN_W,
  parameter int RATE_W  = pdiv_pkg::RATE_W,
  parameter int SEL_W   = pdiv_pkg::SEL_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_en,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       periodic_stb,
  output logic       sec_tick,
  output logic       sqw_out
);
  logic [SEL_W-1:0]   div_sel;
  logic [RATE_W-1:0]  rate_code;
  logic               sqw_en;
  logic               run;
  logic [CHAIN_W-1:0] chain_cnt;
  logic [CHAIN_W-1:0] tap_mask;
  logic               tap_evt;

  pdiv_regs #(.SEL_W(SEL_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .div_sel(div_sel), .rate_code(rate_code), .sqw_en(sqw_en)
  );

  assign run = (div_sel == pdiv_pkg::SEL_RUN);

  pdiv_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .run(run), .tb_en(tb_en),
    .cnt(chain_cnt), .sec_tick(sec_tick)
  );

  pdiv_tap #(.CHAIN_W(CHAIN_W), .RATE_W(RATE_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .run(run), .tb_en(tb_en),
    .rate_code(rate_code), .cnt(chain_cnt), .mask(tap_mask),
    .evt(tap_evt), .periodic_stb(periodic_stb)
  );

  pdiv_sqw u_sqw (
    .clk(clk), .rst_n(rst_n), .sqw_en(sqw_en), .evt(tap_evt),
    .sqw_out(sqw_out)
  );
endmodule

// File: rtl/pdiv_chk.sv
module pdiv_chk #(
  parameter int CHAIN_W = pdiv_pkg::CHAIN_W,
  parameter int RATE_W  = pdiv_pkg::RATE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tb_en,
  input logic               run,
  input logic [RATE_W-1:0]  rate_code,
  input logic               sqw_en,
  input logic [CHAIN_W-1:0] chain_cnt,
  input logic [CHAIN_W-1:0] tap_mask,
  input logic               periodic_stb,
  input logic               sec_tick,
  input logic               sqw_out
);
  // R2
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!periodic_stb && !sec_tick && chain_cnt == '0));

  // R3
  code_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |=> !periodic_stb);

  // R4
  stb_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_stb |-> ((chain_cnt & $past(tap_mask)) == '0 && $past(tb_en)));

  // R6
  sec_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (chain_cnt == '0 && $past(tb_en)));

  // R7
  sqw_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |=> !sqw_out);

  // R7
  sqw_moves_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sqw_out) && $past(sqw_en)) |-> periodic_stb);

  // R9
  stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_stb |=> !periodic_stb);
endmodule

bind periodic_divider pdiv_chk #(.CHAIN_W(CHAIN_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .run(run),
  .rate_code(rate_code), .sqw_en(sqw_en), .chain_cnt(chain_cnt),
  .tap_mask(tap_mask), .periodic_stb(periodic_stb), .sec_tick(sec_tick),
  .sqw_out(sqw_out)
);

// File: tb/periodic_divider_tb.sv
module periodic_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       periodic_stb, sec_tick, sqw_out;

  int n_checks = 0;
  int n_fail   = 0;
  int en_seen  = 0;
  int n_sec    = 0;
  int exp_q[$];
  bit sqw_on    = 1'b0;
  bit sqw_model = 1'b0;
  bit done      = 1'b0;

  always #5 clk = ~clk;

  periodic_divider u_dut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .periodic_stb(periodic_stb),
    .sec_tick(sec_tick), .sqw_out(sqw_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Period in enables, stated from the rate code meaning.
  function automatic int period_of(input int code);
    case (code)
      1:       return 128;
      2:       return 256;
      default: return 2 ** (code - 1);
    endcase
  endfunction

  task automatic wr(input bit a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drive_en(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tb_en = 1'b1;
      @(posedge clk); #1;
      if (gap > 0) begin
        tb_en = 1'b0;
        for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
      end
    end
    tb_en = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  // Restart the chain at a code, queue the expected strobes, drive enables.
  task automatic run_rate(input int code, input int nstb, input int gap, input string req);
    int p;
    p = period_of(code);
    wr(1'b0, {4'b0000, 4'(code)});
    wr(1'b0, {4'b0010, 4'(code)});
    en_seen = 0;
    for (int k = 1; k <= nstb; k++) exp_q.push_back(k * p);
    drive_en(nstb * p + 1, gap);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Monitor: counts enables, pops expected strobes, follows the square wave.
  always @(posedge clk) begin
    logic en_now;
    en_now = tb_en;
    #3;
    if (rst_n) begin
      if (en_now) en_seen++;
      if (sec_tick) begin
        n_sec++;
        chk(en_seen == 32768, "R6 sec tick position", en_seen, 32768);
      end
      if (periodic_stb) begin
        if (exp_q.size() == 0) chk(1'b0, "R3/R2 unexpected strobe", en_seen, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(en_seen == e, "R4 strobe position", en_seen, e);
        end
        if (sqw_on) sqw_model = ~sqw_model;
        chk(sqw_out == sqw_model, "R7 square wave", sqw_out, sqw_model);
      end
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd_addr = 1'b0; #1;
    chk(rd_data == 8'h26, "R1 rate reg reset", rd_data, 8'h26);
    rd_addr = 1'b1; #1;
    chk(rd_data == 8'h00, "R1 ctrl reg reset", rd_data, 0);
    chk({periodic_stb, sec_tick, sqw_out} == 3'b000, "R1 outputs reset",
        {periodic_stb, sec_tick, sqw_out}, 0);
    rst_n = 1'b1;

    // R8 readback masking
    wr(1'b0, 8'hFF);
    rd_addr = 1'b0; #1;
    chk(rd_data == 8'h7F, "R8 rate readback", rd_data, 8'h7F);
    wr(1'b1, 8'hFF);
    rd_addr = 1'b1; #1;
    chk(rd_data == 8'h08, "R8 ctrl readback", rd_data, 8'h08);
    sqw_on = 1'b1;

    // R4 default rate, continuous enable, square wave on (R7)
    run_rate(6, 4, 0, "R4 code 6 missing strobes");
    // R4 shortest rate with gapped enable, checks R9 too
    run_rate(3, 5, 2, "R4 code 3 missing strobes");
    // R5 aliased codes
    run_rate(1, 2, 0, "R5 code 1 missing strobes");
    run_rate(2, 2, 0, "R5 code 2 missing strobes");
    // R3 code zero: no strobes over many enables
    run_rate(0, 0, 0, "R3 code 0");
    drive_en(300, 0);
    chk(n_sec == 0, "R3 no sec tick yet", n_sec, 0);

    // R2 non-standard divider select holds everything
    wr(1'b0, 8'h33);
    en_seen = 0;
    drive_en(200, 0);
    chk(n_sec == 0, "R2 held chain no tick", n_sec, 0);
    run_rate(3, 3, 0, "R2 restart strobes");

    // R7 disable square wave
    wr(1'b1, 8'h00);
    sqw_on = 1'b0; sqw_model = 1'b0;
    @(posedge clk); #3;
    chk(sqw_out == 1'b0, "R7 sqw low when disabled", sqw_out, 0);
    run_rate(3, 3, 0, "R7 disabled run strobes");

    // R4 slowest rate and R6 one-second wrap
    sqw_on = 1'b1;
    wr(1'b1, 8'h08);
    n_sec = 0;
    run_rate(15, 2, 0, "R4 code 15 missing strobes");
    chk(n_sec == 1, "R6 one tick per 32768", n_sec, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule